// File: doc/BRIEF.md
# Configuration Space Access Sequencer

This block sits between a host that issues configuration reads and writes and a bridge whose register window accepts only full 32-bit cycles. A host request names a target bus, a device-function number, a register offset, a transfer size (byte, halfword or word), a direction and write data. The block turns each request into register cycles. First it writes a formatted address word into the bridge's address register. Then it reads or writes the bridge's data register. Byte and halfword reads are cut out of the returned word. Byte and halfword writes become a read, a merge and a second address-then-data write.

The host side is two valid/ready streams. A request moves when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is high only while the block is idle, so exactly one request is in flight. A response moves when `rsp_valid` and `rsp_ready` are both high. The response stays on the port, unchanged, for as long as `rsp_ready` is held low. The register side is also valid/ready. The block holds each register cycle stable until `reg_ready` is seen. Read data are taken from `reg_rdata` in the cycle of the handshake. If the bridge never answers, a stall counter ends the wait.

Top module: `cfg_space_seq`

## Requirements
- R1: After reset, `req_ready` is 1, and `busy`, `rsp_valid` and `reg_valid` are 0.
- R2: Every accepted in-range request starts with a write to register offset 0x500. That write carries the address word {8'h00, bus, devfn, offset[7:2], 1'b0, type1}. The data cycle follows at offset 0x504, always as a full 32-bit cycle.
- R3: The type1 bit (bit 0 of the address word) is 1 exactly when the target bus is nonzero.
- R4: A request with bus > 7 or devfn > 127 makes no register cycle and responds with status 1. For a read, the data are all ones at the requested size (0xFF, 0xFFFF or 0xFFFFFFFF, zero-extended). For a write, the data are 0.
- R5: A byte read (size code 0) returns, zero-extended, the byte at lane (offset[1:0] XOR 3) counted from the most significant byte of the data word.
- R6: A halfword read (size code 1) returns, zero-extended, the half at index (offset[1] XOR 1) counted from the upper half. A word read (size code 2) returns the whole word.
- R7: A word write makes exactly two register cycles: the address write, then a data write of the request data. It responds with status 0 and data 0.
- R8: A byte or halfword write makes four cycles: address write, data read, a fresh address write with the same word, and a data write. The written word equals the word that was read, with only the selected lane replaced.
- R9: A register cycle that gets no `reg_ready` for TIMEOUT_CYCLES cycles (default 256) is dropped. The response then has status 1, and a read returns all ones at the requested size.
- R10: If the preliminary read of a byte or halfword write times out, no write cycle follows and status 1 is reported.
- R11: `busy` is high and `req_ready` low from request acceptance until the response handshake. A stalled response holds its data and status.
- R12: While `reg_valid` is high without `reg_ready`, and no timeout occurs, the register cycle's address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device-function number |
| req_offset | input | 8 | Register byte offset |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write data, right-aligned for sub-word sizes |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_status | output | 1 | 0 success, 1 not-found or timeout |
| rsp_rdata | output | 32 | Read data, zero-extended; 0 for writes |
| busy | output | 1 | A request is in flight |
| reg_valid | output | 1 | Register cycle offered |
| reg_ready | input | 1 | Register cycle completes |
| reg_write | output | 1 | 1 write, 0 read |
| reg_addr | output | 12 | Register offset in the bridge window |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, valid with reg_ready |

## Verification
The bench aims at lane steering at all four byte offsets and both half offsets. If the XOR were dropped or applied the wrong way round, the mirrored lane would come back. It probes the range edges (bus 7 against 8, devfn 127 against 128). An off-by-one there either puts cycles on the register port or returns data for a target that must be rejected. Sub-word writes are checked against the bridge model's memory. A merge that clobbers neighbouring lanes, or that skips the second address phase, shows up as a wrong stored word or a wrong cycle count. A silent data register covers the read timeout and the abandoned write. A design that wrote anyway after a failed pre-read would show an extra cycle.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [7:0]  offset;
    xfer_size_e  size;
    logic        write;
    logic [31:0] wdata;
  } cfg_req_t;
endpackage

// File: rtl/cfg_addr_fmt.sv
module cfg_addr_fmt #(
  parameter int MAX_BUS   = 7,
  parameter int MAX_DEVFN = 127
) (
  input  logic [7:0]  bus,
  input  logic [7:0]  devfn,
  input  logic [7:0]  offset,
  output logic [31:0] addr_word,
  output logic        in_range
);
  logic type1;

  always_comb begin
    type1     = (bus != 8'd0);
    in_range  = (32'(bus) <= MAX_BUS) && (32'(devfn) <= MAX_DEVFN);
    addr_word = {8'h00, bus, devfn, offset[7:2], 1'b0, type1};
  end
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit
  import cfg_seq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] word_in,
  input  logic [1:0]    offset,
  input  xfer_size_e    size,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] merged
);
  localparam int NLANE = DW / 8;

  logic [1:0] byte_idx;
  logic       half_idx;

  assign byte_idx = offset ^ 2'b11;
  assign half_idx = offset[1] ^ 1'b1;

  always_comb begin
    rd_val = '0;
    case (size)
      SZ_BYTE: begin
        case (byte_idx)
          2'd0:    rd_val[7:0] = word_in[31:24];
          2'd1:    rd_val[7:0] = word_in[23:16];
          2'd2:    rd_val[7:0] = word_in[15:8];
          default: rd_val[7:0] = word_in[7:0];
        endcase
      end
      SZ_HALF: rd_val[15:0] = half_idx ? word_in[15:0] : word_in[31:16];
      default: rd_val = word_in;
    endcase
  end

  // lane g counted from the most significant byte
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int HI = DW - 1 - 8 * g;
    logic       sel;
    logic [7:0] src;
    always_comb begin
      case (size)
        SZ_BYTE: sel = (32'(byte_idx) == g);
        SZ_HALF: sel = (32'(half_idx) == g / 2);
        default: sel = 1'b1;
      endcase
      case (size)
        SZ_BYTE: src = wdata[7:0];
        SZ_HALF: src = (g % 2 == 0) ? wdata[15:8] : wdata[7:0];
        default: src = wdata[HI -: 8];
      endcase
      merged[HI -: 8] = sel ? src : word_in[HI -: 8];
    end
  end
endmodule

// File: rtl/cfg_stall_timer.sv
module cfg_stall_timer #(
  parameter int LIMIT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || expired) cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  assert_cnt_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run && !expired |=> cnt != '0 || !run);
endmodule

// File: rtl/cfg_space_seq.sv
module cfg_space_seq
  import cfg_seq_pkg::*;
#(
  parameter int          MAX_BUS        = 7,
  parameter int          MAX_DEVFN      = 127,
  parameter int          TIMEOUT_CYCLES = 256,
  parameter int          RAW            = 12,
  parameter logic [11:0] ADDR_REG_OFS   = 12'h500,
  parameter logic [11:0] DATA_REG_OFS   = 12'h504
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [7:0]     req_bus,
  input  logic [7:0]     req_devfn,
  input  logic [7:0]     req_offset,
  input  logic [1:0]     req_size,
  input  logic           req_write,
  input  logic [31:0]    req_wdata,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic           rsp_status,
  output logic [31:0]    rsp_rdata,
  output logic           busy,
  output logic           reg_valid,
  input  logic           reg_ready,
  output logic           reg_write,
  output logic [RAW-1:0] reg_addr,
  output logic [31:0]    reg_wdata,
  input  logic [31:0]    reg_rdata
);
  seq_state_e  state;
  cfg_req_t    lat;
  logic        pass_pre;
  logic [31:0] aw_q, wbuf_q, rdata_q;
  logic        status_q;

  logic [31:0] fmt_word, lane_word, lane_rd, lane_merged;
  logic        fmt_ok, tmo, hs, accept;
  logic [1:0]  lane_off;
  xfer_size_e  lane_size;

  assign accept    = (state == ST_IDLE) && req_valid;
  assign hs        = reg_valid && reg_ready;
  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_status = status_q;
  assign rsp_rdata  = rdata_q;

  cfg_addr_fmt #(.MAX_BUS(MAX_BUS), .MAX_DEVFN(MAX_DEVFN)) u_fmt (
    .bus(req_bus), .devfn(req_devfn), .offset(req_offset),
    .addr_word(fmt_word), .in_range(fmt_ok)
  );

  assign lane_off  = (state == ST_IDLE) ? req_offset[1:0] : lat.offset[1:0];
  assign lane_size = (state == ST_IDLE) ? xfer_size_e'(req_size) : lat.size;
  assign lane_word = (state == ST_DATA && reg_ready) ? reg_rdata : 32'hFFFF_FFFF;

  cfg_lane_unit #(.DW(32)) u_lane (
    .word_in(lane_word), .offset(lane_off), .size(lane_size),
    .wdata(lat.wdata), .rd_val(lane_rd), .merged(lane_merged)
  );

  cfg_stall_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(reg_valid && !reg_ready), .expired(tmo)
  );

  always_comb begin
    reg_valid = (state == ST_ADDR) || (state == ST_DATA);
    reg_addr  = (state == ST_ADDR) ? ADDR_REG_OFS : DATA_REG_OFS;
    reg_write = (state == ST_ADDR) || (state == ST_DATA && lat.write && !pass_pre);
    reg_wdata = '0;
    if (state == ST_ADDR)                         reg_wdata = aw_q;
    else if (state == ST_DATA && reg_write)       reg_wdata = wbuf_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      lat      <= '0;
      pass_pre <= 1'b0;
      aw_q     <= '0;
      wbuf_q   <= '0;
      rdata_q  <= '0;
      status_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          lat <= '{bus: req_bus, devfn: req_devfn, offset: req_offset,
                   size: xfer_size_e'(req_size), write: req_write, wdata: req_wdata};
          if (!fmt_ok) begin
            state    <= ST_RESP;
            status_q <= 1'b1;
            rdata_q  <= req_write ? 32'h0 : lane_rd;
          end else begin
            state    <= ST_ADDR;
            aw_q     <= fmt_word;
            wbuf_q   <= req_wdata;
            pass_pre <= req_write && (req_size == SZ_BYTE || req_size == SZ_HALF);
          end
        end
        ST_ADDR: begin
          if (hs) state <= ST_DATA;
          else if (tmo) begin
            state    <= ST_RESP;
            status_q <= 1'b1;
            rdata_q  <= lat.write ? 32'h0 : lane_rd;
          end
        end
        ST_DATA: begin
          if (hs) begin
            if (pass_pre) begin
              wbuf_q   <= lane_merged;
              pass_pre <= 1'b0;
              state    <= ST_ADDR;
            end else begin
              state    <= ST_RESP;
              status_q <= 1'b0;
              rdata_q  <= lat.write ? 32'h0 : lane_rd;
            end
          end else if (tmo) begin
            state    <= ST_RESP;
            status_q <= 1'b1;
            pass_pre <= 1'b0;
            rdata_q  <= lat.write ? 32'h0 : lane_rd;
          end
        end
        default: if (rsp_ready) state <= ST_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);
  assert_rsp_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_status));
  assert_regcycle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && !reg_ready && !tmo |=> reg_valid && $stable(reg_addr)
      && $stable(reg_write) && $stable(reg_wdata));
  assert_type1_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_addr == ADDR_REG_OFS |-> reg_wdata[0] == (lat.bus != 8'd0));
  assert_addr_phase_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_addr == ADDR_REG_OFS |-> reg_write);
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reg_valid && !rsp_valid);
endmodule

// File: tb/cfg_space_seq_tb.sv
module cfg_space_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [7:0]  req_bus = '0, req_devfn = '0, req_offset = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_status;
  logic [31:0] rsp_rdata;
  logic        busy, reg_valid, reg_ready, reg_write;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  cfg_space_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
    .rsp_rdata(rsp_rdata), .busy(busy), .reg_valid(reg_valid),
    .reg_ready(reg_ready), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // ---------------- bridge register model ----------------
  logic [31:0] mem [logic [31:0]];
  logic [31:0] cur_aw = '0;
  int          nlog = 0;
  logic [11:0] log_addr [64];
  logic        log_wr   [64];
  logic [31:0] log_data [64];
  int          waitc = 0;
  bit          silent = 0;

  function automatic logic [31:0] peek(input logic [31:0] k);
    if (mem.exists(k)) return mem[k];
    return (k * 32'h9E37_79B1) ^ 32'h5A0F_C3E1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      reg_ready <= 1'b0;
      reg_rdata <= '0;
    end else if (reg_valid && reg_ready) begin
      log_addr[nlog % 64] <= reg_addr;
      log_wr[nlog % 64]   <= reg_write;
      log_data[nlog % 64] <= reg_write ? reg_wdata : reg_rdata;
      nlog <= nlog + 1;
      if (reg_addr == 12'h500 && reg_write) cur_aw <= reg_wdata;
      else if (reg_addr == 12'h504 && reg_write) mem[cur_aw] = reg_wdata;
      reg_ready <= 1'b0;
      waitc <= int'($urandom_range(2, 0));
    end else if (reg_valid) begin
      if (waitc == 0 && !(silent && reg_addr == 12'h504)) begin
        reg_ready <= 1'b1;
        reg_rdata <= peek(cur_aw);
      end else if (waitc != 0) waitc <= waitc - 1;
    end else reg_ready <= 1'b0;
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sized_ones(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] pick(input logic [31:0] w, input logic [7:0] off,
                                       input logic [1:0] sz);
    if (sz == 2'd0) return (w >> (8 * off[1:0])) & 32'hFF;
    if (sz == 2'd1) return (w >> (16 * off[1])) & 32'hFFFF;
    return w;
  endfunction

  function automatic logic [31:0] place(input logic [31:0] w, input logic [7:0] off,
                                        input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] m;
    int sh;
    if (sz == 2'd2) return d;
    sh = (sz == 2'd0) ? 8 * off[1:0] : 16 * off[1];
    m  = ((sz == 2'd0) ? 32'hFF : 32'hFFFF) << sh;
    return (w & ~m) | ((d << sh) & m);
  endfunction

  task automatic do_req(input logic [7:0] bus, input logic [7:0] devfn,
                        input logic [7:0] off, input logic [1:0] sz,
                        input logic wr, input logic [31:0] wd, input string tag);
    logic [31:0] aw, old, exp_data, exp_mem;
    bit          rej, sub;
    int          exp_n, base, bp;
    rej = (bus > 8'd7) || (devfn > 8'd127);
    sub = wr && (sz != 2'd2);
    aw  = {8'h00, bus, devfn, off[7:2], 1'b0, bus != 8'd0};
    old = peek(aw);
    if (wr)                 exp_data = 32'h0;
    else if (rej || silent) exp_data = sized_ones(sz);
    else                    exp_data = pick(old, off, sz);
    if (rej)         exp_n = 0;
    else if (silent) exp_n = 1;
    else             exp_n = sub ? 4 : 2;
    exp_mem = (wr && !rej && !silent) ? place(old, off, sz, wd) : old;
    base = nlog;

    @(negedge clk);
    req_bus = bus; req_devfn = devfn; req_offset = off; req_size = sz;
    req_write = wr; req_wdata = wd; req_valid = 1'b1;
    chk({tag, " R11 ready before accept"}, 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R11 busy after accept"}, 32'(busy), 32'd1);
    while (!rsp_valid) begin
      if (req_ready) chk({tag, " R11 ready while busy"}, 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    chk({tag, " rsp data"}, rsp_rdata, exp_data);
    chk({tag, " rsp status"}, 32'(rsp_status), 32'(rej || silent));
    bp = int'($urandom_range(2, 0));
    for (int i = 0; i < bp; i++) begin
      @(negedge clk);
      chk({tag, " R11 rsp held"}, {rsp_valid, rsp_rdata[30:0]}, {1'b1, exp_data[30:0]});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk({tag, " R11 idle after rsp"}, {30'd0, busy, req_ready}, 32'd1);
    chk({tag, " cycle count"}, 32'(nlog - base), 32'(exp_n));
    if (exp_n >= 1) chk({tag, " R2 addr phase"},
                        {log_wr[base % 64], 19'd0, log_addr[base % 64]}, {1'b1, 19'd0, 12'h500});
    if (exp_n >= 1) chk({tag, " R2 R3 addr word"}, log_data[base % 64], aw);
    if (exp_n >= 2) chk({tag, " R2 data phase"},
                        {log_wr[(base + 1) % 64], 19'd0, log_addr[(base + 1) % 64]},
                        {wr && !sub, 19'd0, 12'h504});
    if (exp_n == 4) begin
      chk({tag, " R8 second addr"}, log_data[(base + 2) % 64], aw);
      chk({tag, " R8 write phase"},
          {log_wr[(base + 3) % 64], 19'd0, log_addr[(base + 3) % 64]}, {1'b1, 19'd0, 12'h504});
    end
    if (wr) chk({tag, " stored word"}, peek(aw), exp_mem);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'd0, req_ready, busy, rsp_valid, reg_valid}, 32'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {28'd0, req_ready, busy, rsp_valid, reg_valid}, 32'b1000);

    for (int o = 0; o < 4; o++) do_req(8'd0, 8'h10, 8'h40 + 8'(o), 2'd0, 1'b0, 0, "R5 byte read");
    do_req(8'd0, 8'h11, 8'h08, 2'd1, 1'b0, 0, "R6 half read low");
    do_req(8'd0, 8'h11, 8'h0A, 2'd1, 1'b0, 0, "R6 half read high");
    do_req(8'd0, 8'h11, 8'h0C, 2'd2, 1'b0, 0, "R6 word read");
    do_req(8'd3, 8'h22, 8'h04, 2'd2, 1'b0, 0, "R3 type1 read");
    do_req(8'd7, 8'd127, 8'hFC, 2'd0, 1'b0, 0, "R4 max in range");
    do_req(8'd8, 8'd0, 8'h00, 2'd0, 1'b0, 0, "R4 bus8 byte");
    do_req(8'd0, 8'd128, 8'h00, 2'd1, 1'b0, 0, "R4 devfn128 half");
    do_req(8'd200, 8'd200, 8'h00, 2'd2, 1'b0, 0, "R4 both word");
    do_req(8'd9, 8'd1, 8'h00, 2'd2, 1'b1, 32'h1234_5678, "R4 rejected write");
    for (int o = 0; o < 4; o++)
      do_req(8'd1, 8'h30, 8'h20 + 8'(o), 2'd0, 1'b1, 32'hA0 + 32'(o), "R8 byte write");
    do_req(8'd0, 8'h31, 8'h10, 2'd1, 1'b1, 32'hBEEF, "R8 half write low");
    do_req(8'd0, 8'h31, 8'h12, 2'd1, 1'b1, 32'hCAFE, "R8 half write high");
    do_req(8'd2, 8'h32, 8'h18, 2'd2, 1'b1, 32'hDEAD_0001, "R7 word write");

    silent = 1;
    do_req(8'd0, 8'h40, 8'h01, 2'd0, 1'b0, 0, "R9 timeout byte read");
    do_req(8'd4, 8'h41, 8'h00, 2'd2, 1'b0, 0, "R9 timeout word read");
    do_req(8'd0, 8'h42, 8'h02, 2'd1, 1'b1, 32'h5555, "R10 pre-read timeout");
    silent = 0;

    for (int n = 0; n < 250; n++) begin
      logic [7:0] b, d;
      b = ($urandom_range(9, 0) < 8) ? 8'($urandom_range(9, 0)) : 8'($urandom);
      d = ($urandom_range(9, 0) < 8) ? 8'($urandom_range(127, 0)) : 8'($urandom);
      do_req(b, d, 8'($urandom), 2'($urandom_range(2, 0)), 1'($urandom),
             $urandom, "R2 R5 R6 R7 R8 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule